// File: doc/BRIEF.md
# Masked Latched Status Register Bank

This block holds the event and alarm status flags of a line-interface controller. A host reads and manages them over a simple synchronous register port. That port has an address, a write strobe, a read strobe and byte-wide write and read data. There are `NREG` latched status registers. Each of their bits is set by one line of the `sts_in` source vector and stays set until the host clears it. A single-cycle pulse on that line reports an event. A line held high reports a level alarm, and an alarm bit sets itself again as long as its condition lasts. One further register reports the live synchronizer status and latches nothing.

The host never clears a flag just by reading it, and it never writes ones to clear. It first writes a byte mask to a latched register. Each mask bit that is one copies the current latched value into that register's read snapshot. Each mask bit that is zero leaves the snapshot bit as it was. The host then reads the register. The read returns the snapshot and clears only the latched bits that the last mask selected and that the snapshot reported as one. Bits that were not selected keep collecting events.

Each latched register has its own interrupt-enable register, and all of them reset to zero. The interrupt output is high while any enabled latched bit is set. The register port is a plain strobe interface and has no valid/ready stream, so it never applies back-pressure. A strobe is accepted in the cycle it is high. The host never asserts the write strobe and the read strobe in the same cycle.

Top module: `stat_bank`

## Requirements
- R1: After reset, every latched bit, snapshot bit, mask-selection bit and interrupt-enable bit is zero, `rdata_o` is 0x00 and `irq_o` is low.
- R2: Bit b of latched register k is fed by `sts_in[k*W+b]`. If that line is high at a clock edge, the bit is one after that edge, and it stays one until a clearing read.
- R3: A write to latched register k (address k, for k below `NREG`) loads every snapshot bit whose mask bit is one from the latched value at that edge. Every snapshot bit whose mask bit is zero keeps its previous value.
- R4: A read of latched register k places that register's snapshot on `rdata_o` one cycle after the read strobe. `rdata_o` then holds that value until the next read.
- R5: A read of register k clears only the latched bits that are one both in the last mask written to k and in the snapshot being returned. All other latched bits keep their value.
- R6: After a clearing read, a bit whose source pulsed reads back zero. A bit whose source is still held high reads back one on the next mask-and-read.
- R7: If a bit's source is high at the same edge as the read that would clear it, the bit stays set.
- R8: A read at address `NREG` returns the `sync_in` value sampled at the read edge, one cycle later. A later read returns the new live value.
- R9: Address `NREG+1+k` is the interrupt-enable register of latched register k. It can be written, and reading it returns the last value written.
- R10: `irq_o` is high exactly while some latched bit is set whose enable bit is one. It rises the cycle after an enabled source is sampled, and a set bit whose enable bit is zero does not raise it.
- R11: After a read, a second read with no new mask write in between returns the same snapshot and clears no latched bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW (3) | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | W (8) | Write data: mask or enable byte |
| rdata_o | output | W (8) | Read data, valid one cycle after `rd_i` |
| sts_in | input | NREG*W (24) | Event and alarm sources, register k in bits k*W+W-1..k*W |
| sync_in | input | W (8) | Live synchronizer status |
| irq_o | output | 1 | Interrupt, high while any enabled latched bit is set |

## Verification
A source that is high at one edge shows in the latched bit and in `irq_o` right after that edge. The bench therefore drives sources for one full cycle from a falling edge and does not look at the result until the next falling edge. A mask write takes its snapshot from the latched value at its own edge. So every mask write is issued at least one edge after the pulse that it is meant to capture. Read data is registered and valid one cycle after the strobe, so each read task samples `rdata_o` at the falling edge that follows the read edge. For the collision case of R7, the source is held high across the read edge itself, and the following mask-and-read pair shows whether the bit survived.

// File: rtl/stat_pkg.sv
package stat_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_LATCH = 2'd1,
    ACC_LIVE  = 2'd2,
    ACC_EN    = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e       kind;
    logic [7:0] idx;
  } dec_t;
endpackage

// File: rtl/stat_decode.sv
module stat_decode
  import stat_pkg::*;
#(
  parameter int NREG = 3,
  parameter int AW   = 3
) (
  input  logic [AW-1:0] addr_i,
  output dec_t          dec_o
);
  always_comb begin
    int a;
    a = int'(addr_i);
    dec_o.kind = ACC_NONE;
    dec_o.idx  = '0;
    if (a < NREG) begin
      dec_o.kind = ACC_LATCH;
      dec_o.idx  = 8'(a);
    end else if (a == NREG) begin
      dec_o.kind = ACC_LIVE;
    end else if (a <= 2*NREG) begin
      dec_o.kind = ACC_EN;
      dec_o.idx  = 8'(a - NREG - 1);
    end
  end
endmodule

// File: rtl/stat_latch_reg.sv
module stat_latch_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         mask_wr_i,
  input  logic [W-1:0] mask_i,
  input  logic         rd_i,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] snap_o
);
  logic [W-1:0] sel_q;
  logic [W-1:0] clr;

  // a read clears only bits that were selected and reported as set
  assign clr = rd_i ? (sel_q & snap_o) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_o <= '0;
      snap_o  <= '0;
      sel_q   <= '0;
    end else begin
      latch_o <= src_i | (latch_o & ~clr);
      if (mask_wr_i) begin
        snap_o <= (mask_i & latch_o) | (~mask_i & snap_o);
        sel_q  <= mask_i;
      end else if (rd_i) begin
        sel_q <= '0;
      end
    end
  end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_pkg::*;
#(
  parameter int W    = 8,
  parameter int NREG = 3,
  localparam int NADDR = 2*NREG + 1,
  localparam int AW    = $clog2(NADDR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    rdata_o,
  input  logic [NREG*W-1:0] sts_in,
  input  logic [W-1:0]    sync_in,
  output logic            irq_o
);
  dec_t         dec;
  logic [W-1:0] latch_q [NREG];
  logic [W-1:0] snap_q  [NREG];
  logic [W-1:0] en_q    [NREG];
  logic [NREG*W-1:0] latch_all, snap_all, en_all;
  logic [W-1:0] rd_mux;

  stat_decode #(.NREG(NREG), .AW(AW)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic hit_latch, hit_en;
    assign hit_latch = (dec.kind == ACC_LATCH) && (dec.idx == 8'(k));
    assign hit_en    = (dec.kind == ACC_EN)    && (dec.idx == 8'(k));

    stat_latch_reg #(.W(W)) u_lat (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (sts_in[k*W +: W]),
      .mask_wr_i (wr_i && hit_latch),
      .mask_i    (wdata_i),
      .rd_i      (rd_i && hit_latch),
      .latch_o   (latch_q[k]),
      .snap_o    (snap_q[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               en_q[k] <= '0;
      else if (wr_i && hit_en)  en_q[k] <= wdata_i;
    end

    assign latch_all[k*W +: W] = latch_q[k];
    assign snap_all[k*W +: W]  = snap_q[k];
    assign en_all[k*W +: W]    = en_q[k];
  end

  always_comb begin
    rd_mux = '0;
    case (dec.kind)
      ACC_LIVE:  rd_mux = sync_in;
      ACC_LATCH: for (int k = 0; k < NREG; k++)
                   if (dec.idx == 8'(k)) rd_mux = snap_q[k];
      ACC_EN:    for (int k = 0; k < NREG; k++)
                   if (dec.idx == 8'(k)) rd_mux = en_q[k];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_o <= '0;
    else if (rd_i)  rdata_o <= rd_mux;
  end

  assign irq_o = |(latch_all & en_all);
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
  parameter int W    = 8,
  parameter int NREG = 3,
  parameter int AW   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [NREG*W-1:0] sts_in,
  input logic [W-1:0]      sync_in,
  input logic [W-1:0]      rdata_o,
  input logic              irq_o,
  input logic [NREG*W-1:0] latch_all,
  input logic [W-1:0]      snap0,
  input logic [NREG*W-1:0] en_all
);
  AST_SRC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_all & $past(sts_in)) == $past(sts_in))); // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_all & ~$past(latch_all) & ~$past(sts_in)) == '0)); // R2
  AST_HOLD_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((latch_all & $past(latch_all)) == $past(latch_all))); // R5
  AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && addr_i == '0) |=> (rdata_o == $past(snap0))); // R4
  AST_LIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && int'(addr_i) == NREG) |=> (rdata_o == $past(sync_in))); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |-> !irq_o); // R10
endmodule

bind stat_bank stat_bank_chk #(.W(W), .NREG(NREG), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .sts_in    (sts_in),
  .sync_in   (sync_in),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .latch_all (latch_all),
  .snap0     (snap_all[W-1:0]),
  .en_all    (en_all)
);

// File: tb/stat_bank_test.sv
module stat_bank_test;
  localparam int W = 8;
  localparam int NREG = 3;
  localparam int AW = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] addr_i = '0;
  logic wr_i = 0, rd_i = 0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic [NREG*W-1:0] sts_in = '0;
  logic [W-1:0] sync_in = '0;
  logic irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stat_bank #(.W(W), .NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .sts_in(sts_in),
    .sync_in(sync_in), .irq_o(irq_o)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(int a, logic [W-1:0] d);
    @(negedge clk);
    addr_i = AW'(a); wdata_i = d; wr_i = 1;
    @(negedge clk);
    wr_i = 0;
  endtask

  task automatic bus_read(int a, output logic [W-1:0] d);
    @(negedge clk);
    addr_i = AW'(a); rd_i = 1;
    @(negedge clk);
    rd_i = 0;
    d = rdata_o;
  endtask

  task automatic pulse(int k, int b);
    @(negedge clk);
    sts_in[k*W+b] = 1'b1;
    @(negedge clk);
    sts_in[k*W+b] = 1'b0;
  endtask

  task automatic mask_read(int k, logic [W-1:0] m, output logic [W-1:0] d);
    bus_write(k, m);
    bus_read(k, d);
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    check("R1 rdata", rdata_o, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    bus_read(NREG+1, d); check("R1 enable reset", d, 8'h00);
    mask_read(0, 8'hFF, d); check("R1 latch reset", d, 8'h00);
  endtask

  task automatic t_event;
    logic [W-1:0] d;
    pulse(0, 0);
    mask_read(0, 8'hFF, d); check("R2/R3/R4 event captured", d, 8'h01);
    mask_read(0, 8'hFF, d); check("R5/R6 event cleared", d, 8'h00);
  endtask

  task automatic t_mask_hold;
    logic [W-1:0] d;
    pulse(1, 1); pulse(1, 2);
    mask_read(1, 8'h02, d); check("R3 partial mask", d, 8'h02);
    mask_read(1, 8'h04, d); check("R3/R5 held bit and unselected bit kept", d, 8'h06);
    mask_read(1, 8'hFF, d); check("R5 selected bits cleared", d, 8'h00);
  endtask

  task automatic t_alarm;
    logic [W-1:0] d;
    @(negedge clk); sts_in[2*W+7] = 1'b1;
    mask_read(2, 8'hFF, d); check("R6 alarm captured", d, 8'h80);
    mask_read(2, 8'hFF, d); check("R6 alarm re-sets", d, 8'h80);
    @(negedge clk); sts_in[2*W+7] = 1'b0;
    mask_read(2, 8'hFF, d); check("R6 alarm held after drop", d, 8'h80);
    mask_read(2, 8'hFF, d); check("R6 alarm cleared", d, 8'h00);
  endtask

  task automatic t_collide;
    logic [W-1:0] d;
    pulse(0, 3);
    bus_write(0, 8'hFF);
    @(negedge clk);
    addr_i = AW'(0); rd_i = 1; sts_in[3] = 1'b1;
    @(negedge clk);
    rd_i = 0; sts_in[3] = 1'b0; d = rdata_o;
    check("R7 read during event", d, 8'h08);
    mask_read(0, 8'hFF, d); check("R7 event not lost", d, 8'h08);
    mask_read(0, 8'hFF, d); check("R7 cleared after", d, 8'h00);
  endtask

  task automatic t_live;
    logic [W-1:0] d;
    @(negedge clk); sync_in = 8'hA5;
    bus_read(NREG, d); check("R8 live read", d, 8'hA5);
    @(negedge clk); sync_in = 8'h3C;
    bus_read(NREG, d); check("R8 live follows input", d, 8'h3C);
    @(negedge clk); sync_in = 8'h00;
    bus_read(NREG, d); check("R8 not latched", d, 8'h00);
  endtask

  task automatic t_irq;
    logic [W-1:0] d;
    bus_write(NREG+1, 8'h10);
    bus_read(NREG+1, d); check("R9 enable readback", d, 8'h10);
    bus_write(NREG+3, 8'h5A);
    bus_read(NREG+3, d); check("R9 enable reg2 readback", d, 8'h5A);
    pulse(0, 5);
    check("R10 disabled bit no irq", {7'd0, irq_o}, 8'h00);
    @(negedge clk); sts_in[4] = 1'b1;
    check("R10 irq not before edge", {7'd0, irq_o}, 8'h00);
    @(negedge clk); sts_in[4] = 1'b0;
    check("R10 irq raised", {7'd0, irq_o}, 8'h01);
    mask_read(0, 8'hFF, d); check("R10 latched value", d, 8'h30);
    check("R10 irq cleared", {7'd0, irq_o}, 8'h00);
    bus_write(NREG+1, 8'h00);
    bus_write(NREG+3, 8'h00);
  endtask

  task automatic t_reread;
    logic [W-1:0] d;
    pulse(1, 0);
    mask_read(1, 8'hFF, d); check("R11 first read", d, 8'h01);
    pulse(1, 0);
    bus_read(1, d); check("R11 reread same snapshot", d, 8'h01);
    mask_read(1, 8'hFF, d); check("R11 reread cleared nothing", d, 8'h01);
    mask_read(1, 8'hFF, d); check("R11 final clear", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_event;
    t_mask_hold;
    t_alarm;
    t_collide;
    t_live;
    t_irq;
    t_reread;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule